// File: doc/BRIEF.md
# I2C Slave Transmitter with Host Handshake

This block is an I2C target that serves read transfers to a bus master on behalf of a local host processor. It watches the synchronised SCL and SDA lines for start and stop conditions. It takes in the first byte after a start and compares the upper seven bits of that byte with a programmable own address. The last bit of that byte gives the transfer direction. When the address matches and the direction is read, the block acknowledges the address, enters transmit mode by itself and stretches the clock until the host supplies the first data byte.

The host sees a data register, a byte-done interrupt flag, a transmit-mode bit and an acknowledge-status bit. Each of these has a clear strobe. After every byte the block raises the flag and holds SCL low. A write of the data register while in transmit mode loads the next byte and lets the clock run. When the master answers a byte with NACK, the host leaves transmit mode and performs a dummy read of the data register. That read frees SCL, and the block then ignores the bus until the next stop or start. Both bus lines are driven only as open-drain lows.

Top module: `i2c_slave_tx`

## Requirements
- R1: After reset, sclDriveLow, sdaDriveLow, irqFlag, xmitMode and ackStat are all 0.
- R2: The first byte after a start condition is taken MSB first. Its bits 7:1 are the address and bit 0 is the direction, where 1 means read. If bits 7:1 equal ownAddr and bit 0 is 1, the block pulls SDA low during the 9th clock and sets xmitMode. It raises irqFlag when the 9th clock falls.
- R3: If the address differs from ownAddr, or the direction bit is 0, SDA stays released in the 9th clock. In that case irqFlag and xmitMode stay 0, SCL is never held, and later bytes are ignored until the next stop or start.
- R4: After each completed byte of a read transfer (address or data), SCL is held low and irqFlag is set. A data register write while xmitMode is 1 releases SCL.
- R5: A written byte is shifted out MSB first. Its first bit appears on SDA when the byte is loaded, and each later bit changes only while SCL is low.
- R6: The block releases SDA during the master's acknowledge clock. It stores the SDA level seen at the 9th rising SCL edge into ackStat, where 1 means NACK, and raises irqFlag when that clock falls.
- R7: Single-cycle strobes irqClr, trsClr and ackClr clear irqFlag, xmitMode and ackStat.
- R8: While SCL is held and xmitMode is 0, a data register read releases SCL, and the bus is then ignored until a stop or start. A read while xmitMode is 1 leaves SCL held.
- R9: A start or stop in the middle of a byte abandons the transfer and clears xmitMode and the SCL hold. A following start with a matching read address is accepted normally.
- R10: rdData shows the shift register, so after the address byte it holds the received address byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | SCL line level |
| sdaIn | input | 1 | SDA line level |
| sclDriveLow | output | 1 | 1 pulls SCL low (clock stretch) |
| sdaDriveLow | output | 1 | 1 pulls SDA low |
| ownAddr | input | ADDR_W | Own 7-bit address |
| wrData | input | ADDR_W+1 | Host write data for the data register |
| dataWr | input | 1 | Host write strobe for the data register |
| dataRd | input | 1 | Host read strobe for the data register |
| rdData | output | ADDR_W+1 | Data register read value |
| irqClr | input | 1 | Clears irqFlag |
| trsClr | input | 1 | Clears xmitMode |
| ackClr | input | 1 | Clears ackStat |
| irqFlag | output | 1 | Byte-done interrupt flag |
| xmitMode | output | 1 | Transmit mode active |
| ackStat | output | 1 | Last acknowledge from master (1 = NACK) |

## Verification
The assertions check four things on every cycle. A clock stretch never begins without the flag. The stretch ends only after the matching host access (a write in transmit mode, a read otherwise) or a bus abort. The SDA drive changes only while the synchronised SCL is low. Transmit mode and the acknowledge status are set only by a read-address match and by a sampling SCL edge. Byte values and their bit order, NACK-terminated transfers, ignored foreign addresses, reads that must not release the clock, and aborts by start or stop in the middle of a byte can only be shown by the bench's bus scenarios.

// File: rtl/i2c_slave_tx_pkg.sv
package i2c_slave_tx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_TX_WAIT,
    ST_TX,
    ST_TX_ACK,
    ST_WAIT_STOP
  } slvState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic cntClr;
    logic cntInc;
    logic shiftIn;
    logic shiftOut;
    logic load;
  } dpCtl_t;

endpackage

// File: rtl/i2c_slave_tx_dp.sv
module i2c_slave_tx_dp
  import i2c_slave_tx_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int SYNC_STAGES = 2,
  localparam int DATA_W     = ADDR_W + 1,
  localparam int CNT_W      = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  dpCtl_t            ctl,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] ownAddr,
  output logic              sclNow,
  output logic              sdaNow,
  output logic              sclRise,
  output logic              sclFall,
  output logic              startDet,
  output logic              stopDet,
  output logic              byteDone,
  output logic              addrMatch,
  output logic              rwBit,
  output logic              txBit,
  output logic [DATA_W-1:0] shiftReg
);

  logic [SYNC_STAGES-1:0] sclSync, sdaSync;
  logic sclPrev, sdaPrev;
  logic [CNT_W-1:0] bitCnt;

  // line synchronisers, idle level is high
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= '1;
      sdaSync <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclSync <= {sclSync[SYNC_STAGES-2:0], sclIn};
      sdaSync <= {sdaSync[SYNC_STAGES-2:0], sdaIn};
      sclPrev <= sclSync[SYNC_STAGES-1];
      sdaPrev <= sdaSync[SYNC_STAGES-1];
    end
  end

  assign sclNow   = sclSync[SYNC_STAGES-1];
  assign sdaNow   = sdaSync[SYNC_STAGES-1];
  assign sclRise  = sclNow & ~sclPrev;
  assign sclFall  = ~sclNow & sclPrev;
  assign startDet = sclNow & sclPrev & sdaPrev & ~sdaNow;
  assign stopDet  = sclNow & sclPrev & ~sdaPrev & sdaNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '1;
      bitCnt   <= '0;
    end else begin
      if (ctl.load)          shiftReg <= wrData;
      else if (ctl.shiftIn)  shiftReg <= {shiftReg[DATA_W-2:0], sdaNow};
      else if (ctl.shiftOut) shiftReg <= {shiftReg[DATA_W-2:0], 1'b1};
      if (ctl.cntClr)        bitCnt <= '0;
      else if (ctl.cntInc)   bitCnt <= bitCnt + 1'b1;
    end
  end

  assign byteDone  = (bitCnt == CNT_W'(DATA_W));
  assign addrMatch = (shiftReg[DATA_W-1:1] == ownAddr);
  assign rwBit     = shiftReg[0];
  assign txBit     = shiftReg[DATA_W-1];

endmodule

// File: rtl/i2c_slave_tx_ctrl.sv
module i2c_slave_tx_ctrl
  import i2c_slave_tx_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   sclRise,
  input  logic   sclFall,
  input  logic   startDet,
  input  logic   stopDet,
  input  logic   sdaNow,
  input  logic   byteDone,
  input  logic   addrMatch,
  input  logic   rwBit,
  input  logic   txBit,
  input  logic   dataWr,
  input  logic   dataRd,
  input  logic   irqClr,
  input  logic   trsClr,
  input  logic   ackClr,
  output dpCtl_t ctl,
  output logic   irqFlag,
  output logic   xmitMode,
  output logic   ackStat,
  output logic   sclDriveLow,
  output logic   sdaDriveLow
);

  slvState_t st, stNext;
  logic setIrq, setHold, relHold, setTrs, takeAck, abort, holdQ;

  always_comb begin
    stNext  = st;
    ctl     = '0;
    setIrq  = 1'b0;
    setHold = 1'b0;
    relHold = 1'b0;
    setTrs  = 1'b0;
    takeAck = 1'b0;
    abort   = startDet | stopDet;
    if (stopDet) begin
      stNext = ST_IDLE;
    end else if (startDet) begin
      stNext     = ST_ADDR;
      ctl.cntClr = 1'b1;
    end else begin
      case (st)
        ST_ADDR: begin
          if (sclRise && !byteDone) begin
            ctl.shiftIn = 1'b1;
            ctl.cntInc  = 1'b1;
          end else if (sclFall && byteDone) begin
            if (addrMatch && rwBit) begin
              stNext = ST_ADDR_ACK;
              setTrs = 1'b1;
            end else begin
              stNext = ST_WAIT_STOP;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (sclFall) begin
            setIrq  = 1'b1;
            setHold = 1'b1;
            stNext  = ST_TX_WAIT;
          end
        end
        ST_TX_WAIT: begin
          if (dataWr && xmitMode) begin
            ctl.load   = 1'b1;
            ctl.cntClr = 1'b1;
            relHold    = 1'b1;
            stNext     = ST_TX;
          end else if (dataRd && !xmitMode) begin
            relHold = 1'b1;
            stNext  = ST_WAIT_STOP;
          end
        end
        ST_TX: begin
          if (sclRise && !byteDone) begin
            ctl.cntInc = 1'b1;
          end else if (sclFall) begin
            if (byteDone) stNext = ST_TX_ACK;
            else          ctl.shiftOut = 1'b1;
          end
        end
        ST_TX_ACK: begin
          if (sclRise) begin
            takeAck = 1'b1;
          end else if (sclFall) begin
            setIrq  = 1'b1;
            setHold = 1'b1;
            stNext  = ST_TX_WAIT;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st       <= ST_IDLE;
      xmitMode <= 1'b0;
      irqFlag  <= 1'b0;
      ackStat  <= 1'b0;
      holdQ    <= 1'b0;
    end else begin
      st <= stNext;
      if (abort)       xmitMode <= 1'b0;
      else if (setTrs) xmitMode <= 1'b1;
      else if (trsClr) xmitMode <= 1'b0;
      if (setIrq)      irqFlag <= 1'b1;
      else if (irqClr) irqFlag <= 1'b0;
      if (takeAck)     ackStat <= sdaNow;
      else if (ackClr) ackStat <= 1'b0;
      if (abort)        holdQ <= 1'b0;
      else if (setHold) holdQ <= 1'b1;
      else if (relHold) holdQ <= 1'b0;
    end
  end

  assign sclDriveLow = holdQ;
  assign sdaDriveLow = (st == ST_ADDR_ACK) | ((st == ST_TX) & ~txBit);

endmodule

// File: rtl/i2c_slave_tx.sv
module i2c_slave_tx
  import i2c_slave_tx_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int SYNC_STAGES = 2,
  localparam int DATA_W     = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sclDriveLow,
  output logic              sdaDriveLow,
  input  logic [ADDR_W-1:0] ownAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              dataWr,
  input  logic              dataRd,
  output logic [DATA_W-1:0] rdData,
  input  logic              irqClr,
  input  logic              trsClr,
  input  logic              ackClr,
  output logic              irqFlag,
  output logic              xmitMode,
  output logic              ackStat
);

  dpCtl_t dpCtl;
  logic sclNow, sdaNow, sclRise, sclFall, startDet, stopDet;
  logic byteDone, addrMatch, rwBit, txBit;

  i2c_slave_tx_dp #(.ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES)) uDp (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .ctl(dpCtl), .wrData(wrData), .ownAddr(ownAddr),
    .sclNow(sclNow), .sdaNow(sdaNow), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet), .byteDone(byteDone),
    .addrMatch(addrMatch), .rwBit(rwBit), .txBit(txBit), .shiftReg(rdData)
  );

  i2c_slave_tx_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet), .sdaNow(sdaNow),
    .byteDone(byteDone), .addrMatch(addrMatch), .rwBit(rwBit), .txBit(txBit),
    .dataWr(dataWr), .dataRd(dataRd), .irqClr(irqClr), .trsClr(trsClr),
    .ackClr(ackClr), .ctl(dpCtl), .irqFlag(irqFlag), .xmitMode(xmitMode),
    .ackStat(ackStat), .sclDriveLow(sclDriveLow), .sdaDriveLow(sdaDriveLow)
  );

endmodule

// File: rtl/i2c_slave_tx_chk.sv
module i2c_slave_tx_chk (
  input logic clk,
  input logic rstN,
  input logic sclDriveLow,
  input logic sdaDriveLow,
  input logic irqFlag,
  input logic xmitMode,
  input logic ackStat,
  input logic dataWr,
  input logic dataRd,
  input logic sclNow,
  input logic sclRise,
  input logic busAbort,
  input logic readMatch
);

  AST_STRETCH_WITH_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sclDriveLow) |-> irqFlag); // R4

  AST_HOLD_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sclDriveLow) |-> $past((dataWr && xmitMode) || (dataRd && !xmitMode) || busAbort)); // R8

  AST_SDA_CHANGES_SCL_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (sdaDriveLow != $past(sdaDriveLow)) |-> !$past(sclNow)); // R5

  AST_TRS_ONLY_ON_READ_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    $rose(xmitMode) |-> $past(readMatch)); // R2

  AST_ACK_ON_SCL_RISE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ackStat) |-> $past(sclRise)); // R6

endmodule

bind i2c_slave_tx i2c_slave_tx_chk uChk (
  .clk(clk), .rstN(rstN), .sclDriveLow(sclDriveLow), .sdaDriveLow(sdaDriveLow),
  .irqFlag(irqFlag), .xmitMode(xmitMode), .ackStat(ackStat),
  .dataWr(dataWr), .dataRd(dataRd), .sclNow(sclNow), .sclRise(sclRise),
  .busAbort(startDet | stopDet), .readMatch(addrMatch & rwBit)
);

// File: tb/tb_i2c_slave_tx.sv
`timescale 1ns/1ps
module tb_i2c_slave_tx;

  localparam int T = 12;
  localparam logic [6:0] OWN = 7'h5A;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic mSclLow = 1'b0, mSdaLow = 1'b0;
  logic sclIn, sdaIn, sclDriveLow, sdaDriveLow;
  logic [7:0] wrData = '0;
  logic dataWr = 0, dataRd = 0, irqClr = 0, trsClr = 0, ackClr = 0;
  logic [7:0] rdData;
  logic irqFlag, xmitMode, ackStat;

  int checks = 0, fails = 0;
  bit done = 0;
  // behavioural model of host-visible state
  bit expIrq = 0, expTrs = 0, expAck = 0, expHold = 0;
  bit [7:0] txQ[$];

  always #2 clk = ~clk;

  assign sclIn = !(mSclLow || sclDriveLow);
  assign sdaIn = !(mSdaLow || sdaDriveLow);

  i2c_slave_tx dut (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .sclDriveLow(sclDriveLow), .sdaDriveLow(sdaDriveLow), .ownAddr(OWN),
    .wrData(wrData), .dataWr(dataWr), .dataRd(dataRd), .rdData(rdData),
    .irqClr(irqClr), .trsClr(trsClr), .ackClr(ackClr),
    .irqFlag(irqFlag), .xmitMode(xmitMode), .ackStat(ackStat)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic compareModel(input string req);
    check(req, "irqFlag", irqFlag, expIrq);
    check(req, "xmitMode", xmitMode, expTrs);
    check(req, "ackStat", ackStat, expAck);
    check(req, "sclDriveLow", sclDriveLow, expHold);
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic waitSclHigh();
    for (int g = 0; g < 5000 && !sclIn; g++) @(negedge clk);
  endtask

  task automatic mStart();
    mSdaLow = 0; waitClk(T);
    mSclLow = 0; waitSclHigh(); waitClk(T);
    mSdaLow = 1; waitClk(T);
    mSclLow = 1; waitClk(T);
  endtask

  task automatic mStop();
    mSdaLow = 1; waitClk(T);
    mSclLow = 0; waitSclHigh(); waitClk(T);
    mSdaLow = 0; waitClk(T);
  endtask

  task automatic sendBit(input bit b);
    mSdaLow = !b; waitClk(T);
    mSclLow = 0; waitSclHigh(); waitClk(T);
    mSclLow = 1; waitClk(T);
  endtask

  task automatic readBit(output bit b);
    mSdaLow = 0; waitClk(T);
    mSclLow = 0; waitSclHigh(); waitClk(T/2);
    b = sdaIn; waitClk(T/2);
    mSclLow = 1; waitClk(T);
  endtask

  task automatic sendByte(input bit [7:0] v);
    for (int i = 7; i >= 0; i--) sendBit(v[i]);
  endtask

  task automatic readByte(output bit [7:0] v);
    for (int i = 7; i >= 0; i--) begin
      bit b;
      readBit(b);
      v[i] = b;
    end
  endtask

  task automatic host(input bit w, input bit r, input bit ic, input bit tc,
                      input bit ac, input logic [7:0] d);
    wrData = d; dataWr = w; dataRd = r; irqClr = ic; trsClr = tc; ackClr = ac;
    @(negedge clk);
    dataWr = 0; dataRd = 0; irqClr = 0; trsClr = 0; ackClr = 0;
    waitClk(3);
  endtask

  task automatic releaseForStretch();
    mSdaLow = 0; waitClk(2);
    mSclLow = 0; waitClk(20);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL ALL watchdog actual=expired expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    bit a;
    bit [7:0] v;
    waitClk(5);
    rstN = 1;
    waitClk(5);
    // R1 reset state
    compareModel("R1");
    check("R1", "sdaDriveLow", sdaDriveLow, 0);

    // ---- read transfer: two bytes, second ends with NACK
    txQ.push_back(8'hC3);
    txQ.push_back(8'h29);
    mStart();
    sendByte({OWN, 1'b1});
    readBit(a);
    check("R2", "address ACK level", a, 0);
    expIrq = 1; expTrs = 1; expHold = 1;
    compareModel("R2");
    check("R10", "rdData after address", rdData, {OWN, 1'b1});
    releaseForStretch();
    check("R4", "SCL stretched", sclIn, 0);
    host(0, 0, 1, 0, 0, 8'h00); expIrq = 0;
    v = txQ.pop_front();
    host(1, 0, 0, 0, 0, v); expHold = 0;
    check("R4", "SCL released by write", sclDriveLow, expHold);
    begin
      bit [7:0] got;
      readByte(got);
      check("R5", "first data byte", got, v);
    end
    sendBit(0);
    expIrq = 1; expHold = 1; expAck = 0;
    compareModel("R6");
    host(0, 1, 0, 0, 0, 8'h00);
    check("R8", "read in transmit mode keeps SCL", sclDriveLow, 1);
    releaseForStretch();
    check("R4", "SCL stretched second byte", sclIn, 0);
    host(0, 0, 1, 0, 0, 8'h00); expIrq = 0;
    v = txQ.pop_front();
    host(1, 0, 0, 0, 0, v); expHold = 0;
    begin
      bit [7:0] got;
      readByte(got);
      check("R5", "second data byte", got, v);
    end
    sendBit(1);
    expIrq = 1; expHold = 1; expAck = 1;
    compareModel("R6");
    host(0, 0, 1, 1, 1, 8'h00);
    expIrq = 0; expTrs = 0; expAck = 0;
    compareModel("R7");
    host(0, 1, 0, 0, 0, 8'h00); expHold = 0;
    compareModel("R8");
    sendBit(1);
    check("R8", "bus ignored after release irqFlag", irqFlag, 0);
    check("R8", "bus ignored after release sclDriveLow", sclDriveLow, 0);
    mStop();
    compareModel("R8");

    // ---- foreign address and write direction
    mStart();
    sendByte({7'h33, 1'b1});
    readBit(a);
    check("R3", "no ACK for foreign address", a, 1);
    compareModel("R3");
    sendByte(8'hFF);
    readBit(a);
    check("R3", "later byte ignored", a, 1);
    compareModel("R3");
    mStop();
    mStart();
    sendByte({OWN, 1'b0});
    readBit(a);
    check("R3", "no ACK for write direction", a, 1);
    compareModel("R3");
    mStop();

    // ---- aborts in the middle of a byte
    mStart();
    for (int i = 7; i >= 4; i--) sendBit(OWN[i-1]);
    mStop();
    compareModel("R9");
    mStart();
    for (int i = 7; i >= 5; i--) sendBit(OWN[i-1]);
    mStart();
    sendByte({OWN, 1'b1});
    readBit(a);
    check("R9", "ACK after repeated start", a, 0);
    expIrq = 1; expTrs = 1; expHold = 1;
    compareModel("R9");
    host(0, 0, 1, 0, 0, 8'h00); expIrq = 0;
    host(1, 0, 0, 0, 0, 8'hFF); expHold = 0;
    readBit(a);
    check("R5", "abort byte bit7", a, 1);
    readBit(a);
    check("R5", "abort byte bit6", a, 1);
    mStart();
    expTrs = 0;
    compareModel("R9");
    check("R9", "SDA released after abort", sdaDriveLow, 0);
    mStop();
    compareModel("R9");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule